// File: doc/BRIEF.md
# Banked Write-One-to-Clear Fault Status Register

This block holds a 32-bit sticky fault status word in two banked copies, one for the secure world and one for the non-secure world. Hardware raises status bits through a per-bit set mask that carries a security-state select. Software reaches the register through a four-byte window on a simple memory-mapped bus. It can use byte, halfword or word accesses, and it clears bits by writing ones.

The bits of byte lane 1 (bits [15:8]) form a field that both security states share. That field lives only in the non-secure copy. A read from either state sees it, and a secure write clears it. The secure copy never holds those bits.

A read returns its data on `rd_data` one cycle after the access, with `rd_valid` high. A write takes effect on the clock edge that samples it. A fault set that arrives in the same cycle as a clear of the same bit takes priority over the clear.

Top module: `flt_stat_bank`

## Requirements
- R1: After reset both copies are all zero, `rd_valid` is low, and a word read from either security state returns 0.
- R2: `acc_size` uses the encoding 0 = 1 byte (any offset), 1 = 2 bytes (offset 0 or 2) and 2 = 4 bytes (offset 0). Value 3, or an offset outside these rules, is misaligned: the read data is 0 and a write changes nothing.
- R3: A read access (`acc_en`=1, `acc_wr`=0) gives `rd_valid`=1 in the next cycle, and only then. `rd_data` is the composed 32-bit value shifted right by 8×offset, with all bits above 8×size-in-bytes forced to 0.
- R4: A write clears every stored bit where the write data, shifted left by 8×offset and restricted to the accessed byte lanes, is 1. All other bits keep their value.
- R5: The access's security bit selects the copy: `acc_sec`=1 uses the secure copy and `acc_sec`=0 uses the non-secure copy. A non-secure write never changes the secure copy.
- R6: Bits [15:8] of any read come from the non-secure copy, whatever the security state of the access.
- R7: A secure write clears the selected bits in the secure copy and also clears the selected bits among [15:8] of the non-secure copy. It leaves the other non-secure bits unchanged.
- R8: A set with `set_sec`=0 sets `set_mask` bits in the non-secure copy. A set with `set_sec`=1 sets bits outside [15:8] in the secure copy and bits [15:8] in the non-secure copy. Bits [15:8] of the secure copy stay 0.
- R9: When a set and a write-one-to-clear hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sec | input | 1 | Security state of the access, 1 = secure |
| acc_off | input | 2 | Byte offset within the window |
| acc_size | input | 2 | Access size code (see R2) |
| acc_wdata | input | 32 | Write data, right-aligned to the access |
| set_mask | input | 32 | Per-bit fault set request |
| set_sec | input | 1 | Security state of the fault set, 1 = secure |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, right-aligned |

## Verification
The bench sets the non-secure and secure copies with different patterns (alternating nibbles against all ones). This means a read from the wrong bank, or a shared field taken from the wrong copy, shows up as a different word. Byte and halfword reads at every legal offset exercise the extraction shift and the width mask. Misaligned reads and writes are tried with all-ones data, so any leak of the data or of the write is visible. Clears go through non-secure and secure writes of each size to separate the banking of the shared lane from the private lanes. A same-cycle set and clear shows whether the set takes priority.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int SH_W   = OFF_W + 3;
    localparam int BANKS  = 2;
    localparam int BK_NS  = 0;
    localparam int BK_SEC = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [BANKS-1:0][DATA_W-1:0] bank;
        logic                         rvalid;
        logic [DATA_W-1:0]            rdata;
    } fsr_state_t;
endpackage

// File: rtl/fsr_lane_dec.sv
module fsr_lane_dec
    import fsr_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic              ok,
    output logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] rmask,
    output logic [SH_W-1:0]   shamt
);
    logic [LANES-1:0] lo_lanes;
    logic [LANES-1:0] at_lanes;

    always_comb begin
        ok       = 1'b0;
        lo_lanes = '0;
        case (acc_size_e'(size))
            SZ_BYTE: begin ok = 1'b1;          lo_lanes = LANES'(1); end
            SZ_HALF: begin ok = (off[0] == 1'b0); lo_lanes = LANES'(3); end
            SZ_WORD: begin ok = (off == '0);    lo_lanes = '1;        end
            default: begin ok = 1'b0;          lo_lanes = '0;        end
        endcase
        at_lanes = lo_lanes << off;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wmask[8*i +: 8] = {8{at_lanes[i] & ok}};
        assign rmask[8*i +: 8] = {8{lo_lanes[i] & ok}};
    end

    assign shamt = {off, 3'b000};
endmodule

// File: rtl/fsr_route.sv
module fsr_route
    import fsr_pkg::*;
#(
    parameter int SHARED_LANE = 1
) (
    input  logic                         wr_go,
    input  logic                         acc_sec,
    input  logic [DATA_W-1:0]            clr_vec,
    input  logic [DATA_W-1:0]            set_mask,
    input  logic                         set_sec,
    output logic [BANKS-1:0][DATA_W-1:0] clr,
    output logic [BANKS-1:0][DATA_W-1:0] set
);
    localparam logic [DATA_W-1:0] SH_MASK = DATA_W'(8'hFF) << (8 * SHARED_LANE);

    always_comb begin
        clr = '0;
        set = '0;
        if (wr_go) begin
            if (acc_sec) begin
                clr[BK_SEC] = clr_vec & ~SH_MASK;
                clr[BK_NS]  = clr_vec & SH_MASK;
            end else begin
                clr[BK_NS]  = clr_vec;
            end
        end
        if (set_sec) begin
            set[BK_SEC] = set_mask & ~SH_MASK;
            set[BK_NS]  = set_mask & SH_MASK;
        end else begin
            set[BK_NS]  = set_mask;
        end
    end
endmodule

// File: rtl/fsr_bank_next.sv
module fsr_bank_next
    import fsr_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] clr,
    input  logic [DATA_W-1:0] set,
    output logic [DATA_W-1:0] nxt
);
    assign nxt = (cur & ~clr) | set;
endmodule

// File: rtl/flt_stat_bank.sv
module flt_stat_bank
    import fsr_pkg::*;
#(
    parameter int SHARED_LANE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_sec,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] set_mask,
    input  logic              set_sec,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] SH_MASK = DATA_W'(8'hFF) << (8 * SHARED_LANE);

    fsr_state_t d, q;

    logic                         ok;
    logic [DATA_W-1:0]            wmask, rmask;
    logic [SH_W-1:0]              shamt;
    logic [DATA_W-1:0]            clr_vec;
    logic [BANKS-1:0][DATA_W-1:0] clr, set, nxt;
    logic [DATA_W-1:0]            composed;
    logic [DATA_W-1:0]            sec_cur, ns_cur;

    fsr_lane_dec u_dec (
        .off   (acc_off),
        .size  (acc_size),
        .ok    (ok),
        .wmask (wmask),
        .rmask (rmask),
        .shamt (shamt)
    );

    assign clr_vec = (acc_wdata << shamt) & wmask;

    fsr_route #(.SHARED_LANE(SHARED_LANE)) u_route (
        .wr_go    (acc_en & acc_wr & ok),
        .acc_sec  (acc_sec),
        .clr_vec  (clr_vec),
        .set_mask (set_mask),
        .set_sec  (set_sec),
        .clr      (clr),
        .set      (set)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        fsr_bank_next u_next (
            .cur (q.bank[b]),
            .clr (clr[b]),
            .set (set[b]),
            .nxt (nxt[b])
        );
    end

    assign sec_cur = q.bank[BK_SEC];
    assign ns_cur  = q.bank[BK_NS];

    always_comb begin
        composed = (acc_sec ? (sec_cur & ~SH_MASK) : ns_cur) | (ns_cur & SH_MASK);
        d        = q;
        d.bank   = nxt;
        d.rvalid = acc_en & ~acc_wr;
        d.rdata  = (acc_en & ~acc_wr) ? ((composed >> shamt) & rmask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.rvalid;
    assign rd_data  = q.rdata;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int SHARED_LANE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_sec,
    input logic [OFF_W-1:0]  acc_off,
    input logic [1:0]        acc_size,
    input logic [DATA_W-1:0] set_mask,
    input logic              set_sec,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] sec_cur,
    input logic [DATA_W-1:0] ns_cur
);
    localparam logic [DATA_W-1:0] SH_MASK = DATA_W'(8'hFF) << (8 * SHARED_LANE);

    logic aligned;
    assign aligned = (acc_size == 2'd0) ||
                     (acc_size == 2'd1 && acc_off[0] == 1'b0) ||
                     (acc_size == 2'd2 && acc_off == '0);

    assert_bad_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !aligned) |=> (rd_data == '0));

    assert_bad_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !aligned && set_mask == '0) |=> ($stable(sec_cur) && $stable(ns_cur)));

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> rd_valid);

    assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> !rd_valid);

    assert_ns_write_spares_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_sec && set_mask == '0) |=> $stable(sec_cur));

    assert_sec_shared_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_cur & SH_MASK) == '0);

    assert_ns_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && !set_sec) |=> ((ns_cur & $past(set_mask)) == $past(set_mask)));

    assert_ns_rise_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ns_cur & ~$past(ns_cur) & ~$past(set_mask)) == '0));
endmodule

bind flt_stat_bank fsr_checker #(.SHARED_LANE(SHARED_LANE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_sec  (acc_sec),
    .acc_off  (acc_off),
    .acc_size (acc_size),
    .set_mask (set_mask),
    .set_sec  (set_sec),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .sec_cur  (sec_cur),
    .ns_cur   (ns_cur)
);

// File: tb/sim_flt_stat_bank.sv
module sim_flt_stat_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SHM = 32'h0000_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_sec = 1'b0, set_sec = 1'b0;
    logic [1:0]  acc_off = '0, acc_size = '0;
    logic [31:0] acc_wdata = '0, set_mask = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_sec = '0, m_ns = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flt_stat_bank u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sec(acc_sec),
        .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .set_mask(set_mask), .set_sec(set_sec), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic bit fits(input logic [1:0] sz, input logic [1:0] off);
        return (sz == 2'd0) || (sz == 2'd1 && !off[0]) || (sz == 2'd2 && off == 2'd0);
    endfunction

    function automatic logic [31:0] span(input logic [1:0] sz);
        case (sz)
            2'd0: return 32'h0000_00FF;
            2'd1: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one bus cycle, model updated, expected read pushed.
    task automatic op(input bit en, input bit wr, input bit sec, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] wd,
                      input logic [31:0] sm, input bit ss, input string req);
        logic [31:0] comp, v;
        @(posedge clk); #1;
        acc_en = en; acc_wr = wr; acc_sec = sec; acc_off = off; acc_size = sz;
        acc_wdata = wd; set_mask = sm; set_sec = ss;
        if (en && !wr) begin
            comp = (sec ? m_sec : m_ns) | (m_ns & SHM);
            exp_q.push_back(fits(sz, off) ? ((comp >> (8*off)) & span(sz)) : 32'h0);
            tag_q.push_back(req);
        end
        if (en && wr && fits(sz, off)) begin
            v = (wd & span(sz)) << (8*off);
            if (sec) begin m_sec &= ~v; m_ns &= ~(v & SHM); end
            else     m_ns &= ~v;
        end
        if (ss) begin m_sec |= sm & ~SHM; m_ns |= sm & SHM; end
        else    m_ns |= sm;
    endtask

    task automatic rd(input bit sec, input logic [1:0] off, input logic [1:0] sz, input string req);
        op(1, 0, sec, off, sz, 32'h0, 32'h0, 0, req);
    endtask

    task automatic wrt(input bit sec, input logic [1:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input string req);
        op(1, 1, sec, off, sz, wd, 32'h0, 0, req);
    endtask

    task automatic fset(input logic [31:0] sm, input bit ss, input string req);
        op(0, 0, 0, 2'd0, 2'd0, 32'h0, sm, ss, req);
    endtask

    // Monitor: pop and compare as results appear.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R3: actual rd_valid=1 expected no pending read");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
        rd(0, 2'd0, 2'd2, "R1 ns word");
        rd(1, 2'd0, 2'd2, "R1 sec word");
        fset(32'hA5A5_5A5A, 0, "R8 ns set");
        rd(0, 2'd0, 2'd2, "R8 ns word after set");
        rd(1, 2'd0, 2'd2, "R6 sec sees shared lane");
        fset(32'hFFFF_FFFF, 1, "R8 sec set");
        rd(1, 2'd0, 2'd2, "R8 sec word after set");
        rd(0, 2'd0, 2'd2, "R8 shared bits landed in ns");
        rd(0, 2'd1, 2'd0, "R3 byte off1");
        rd(0, 2'd2, 2'd1, "R3 half off2");
        rd(0, 2'd3, 2'd0, "R3 byte off3");
        rd(1, 2'd2, 2'd1, "R3 sec half off2");
        rd(0, 2'd1, 2'd1, "R2 half off1 read");
        rd(0, 2'd2, 2'd2, "R2 word off2 read");
        rd(0, 2'd0, 2'd3, "R2 size3 read");
        wrt(0, 2'd1, 2'd2, 32'hFFFF_FFFF, "R2 misaligned write");
        wrt(0, 2'd0, 2'd3, 32'hFFFF_FFFF, "R2 size3 write");
        rd(0, 2'd0, 2'd2, "R2 ns unchanged after misaligned writes");
        wrt(0, 2'd3, 2'd0, 32'hFFFF_FFF0, "R4 ns byte clear off3");
        rd(0, 2'd0, 2'd2, "R4 ns after byte clear");
        rd(1, 2'd0, 2'd2, "R5 sec untouched by ns write");
        wrt(0, 2'd2, 2'd1, 32'h0000_0005, "R4 ns half clear off2");
        rd(0, 2'd0, 2'd2, "R4 ns after half clear");
        wrt(0, 2'd1, 2'd0, 32'h0000_000F, "R6 ns clears shared");
        rd(1, 2'd0, 2'd2, "R6 sec read reflects ns shared clear");
        wrt(1, 2'd1, 2'd0, 32'h0000_00F0, "R7 sec clears shared");
        rd(0, 2'd0, 2'd2, "R7 ns shared cleared by sec write");
        wrt(1, 2'd0, 2'd2, 32'h0000_00FF, "R7 sec word clear");
        rd(0, 2'd0, 2'd2, "R7 ns private lanes kept");
        rd(1, 2'd0, 2'd2, "R5 sec after own clear");
        op(1, 1, 0, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R9 ns set vs clear");
        rd(0, 2'd0, 2'd2, "R9 ns set wins");
        op(1, 1, 1, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0001_0000, 1, "R9 sec set vs clear");
        rd(1, 2'd0, 2'd2, "R9 sec set wins");
        op(0, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, 0, "idle");
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 no pending reads left", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule